// File: doc/BRIEF.md
# Parity Puncturing Rate Refiner

This block sits between a systematic channel encoder and the rest of the transmit chain. It takes a single-bit stream in which every bit is tagged as either systematic or parity, and it deletes a programmable share of the parity bits. The systematic bits are never touched. The keep fraction is N/16, with N from 8 to 16. Combined with the encoder's coarse rate r, this gives an overall code rate of r/(r + (N/16)(1-r)). Five coarse rates times nine fine settings give a dense ladder of 45 rates, from 1/2 up to 32/33.

The kept parity positions come from a 4-bit phase accumulator. N is added on each parity bit, and the bit is kept when the sum carries out of 16. This spreads the kept bits evenly. The accumulator restarts at each frame, so a given setting always gives the same deletion pattern.

Input and output use valid/ready handshakes and carry a frame-end flag. The output frame-end flag always sits on the final bit actually emitted, even when the last input bit was a deleted parity bit. When each frame closes, the block reports how many bits it emitted for that frame.

Top module: `punct_rate_ctrl`

## Requirements
- R1: Every systematic bit (`in_par`=0) is forwarded with its value unchanged, in input order and interleaved with the kept parity bits in their original order.
- R2: For parity bits (`in_par`=1), a 4-bit phase starts at 0 at each frame start. The bit is kept when phase + N is 16 or more. The phase then becomes (phase + N) mod 16.
- R3: With N = 16, every parity bit is kept, and the output stream equals the input stream.
- R4: Of every 16 consecutive parity bits, counted from the frame start, exactly N are kept.
- R5: `out_last` is high on exactly one emitted bit per frame, the final one. This holds even when the last input bit was a deleted parity bit.
- R6: After each frame, `frame_bits_valid` pulses for one cycle. At that pulse, `frame_bits` equals the number of systematic bits plus the number of kept parity bits of that frame.
- R7: A `rate_sel` value below 8 or above 16 is treated as 16. It also sets `cfg_err`, which stays high until reset.
- R8: While `out_valid` is high and `out_ready` is low, `out_bit` and `out_last` hold their values. Backpressure neither loses nor duplicates a bit.
- R9: After reset, `out_valid`, `frame_bits_valid` and `cfg_err` are low, and `in_ready` is high.
- R10: A frame in which no bit is kept produces no output bit. It still reports `frame_bits` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 5 | Fine setting N (kept parity bits per 16); hold stable within a frame |
| in_valid | input | 1 | Input bit present |
| in_ready | output | 1 | Block accepts the input bit this cycle |
| in_bit | input | 1 | Coded bit value |
| in_par | input | 1 | 1 = parity bit, 0 = systematic bit |
| in_last | input | 1 | Final input bit of the frame |
| out_valid | output | 1 | Output bit present |
| out_ready | input | 1 | Downstream accepts the output bit |
| out_bit | output | 1 | Emitted bit value |
| out_last | output | 1 | Final emitted bit of the frame |
| frame_bits | output | 16 | Emitted bit count of the closed frame |
| frame_bits_valid | output | 1 | One-cycle strobe for `frame_bits` |
| cfg_err | output | 1 | Sticky flag: an out-of-range setting was seen |

## Verification
The bench targets frames whose final input bit is a deleted parity bit. A design that tags the last flag at the input side would then end the frame without any `out_last`, or put the flag on a bit of the next frame. Frames made only of deleted parity bits check that no stray bit or flag appears and that a zero count is still reported. Setting N = 16, then N = 8 and 12 over whole groups of 16, exposes an accumulator that does not restart per frame or that uses the wrong carry test: the kept counts and positions shift. Random backpressure on `out_ready` catches a held bit that is overwritten or emitted twice, and an out-of-range setting checks both the clamp and the sticky error flag.

// File: rtl/punct_pkg.sv
package punct_pkg;
  // One storage slot of the output path
  typedef struct packed {
    logic vld;
    logic data;
    logic last;
  } slot_t;
endpackage

// File: rtl/punct_cfg.sv
module punct_cfg #(
  parameter int DEN_W = 4,
  parameter int MIN_N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEN_W:0]   rate_in,
  output logic [DEN_W:0]   n_eff,
  output logic             cfg_err
);
  localparam logic [DEN_W:0] N_LO = (DEN_W+1)'(MIN_N);
  localparam logic [DEN_W:0] N_HI = (DEN_W+1)'(1 << DEN_W);

  logic bad;
  assign bad   = (rate_in < N_LO) || (rate_in > N_HI);
  assign n_eff = bad ? N_HI : rate_in;

  always_ff @(posedge clk) begin
    if (rst)      cfg_err <= 1'b0;
    else if (bad) cfg_err <= 1'b1;
  end

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);
endmodule

// File: rtl/punct_pattern.sv
module punct_pattern #(
  parameter int DEN_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  input  logic           frame_end,
  input  logic [DEN_W:0] n_eff,
  output logic           keep
);
  logic [DEN_W-1:0] phase;
  logic [DEN_W:0]   sum;

  assign sum  = {1'b0, phase} + n_eff;
  assign keep = sum[DEN_W];

  always_ff @(posedge clk) begin
    if (rst || frame_end) phase <= '0;
    else if (step)        phase <= sum[DEN_W-1:0];
  end

  // R3
  full_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (step && n_eff == (DEN_W+1)'(1 << DEN_W)) |-> keep);
endmodule

// File: rtl/punct_hold.sv
module punct_hold
  import punct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_fire,
  input  logic             in_keep,
  input  logic             in_bit,
  input  logic             in_last,
  output logic             in_ready,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_bit,
  output logic             out_last,
  output logic [CNT_W-1:0] cnt_out,
  output logic             cnt_valid
);
  slot_t            hold_q, out_q;
  logic [CNT_W-1:0] run_cnt;
  logic             o_free, push_new, flush, empty_end;

  assign o_free    = !out_q.vld || out_ready;
  assign in_ready  = !(hold_q.vld && hold_q.last) && (!hold_q.vld || o_free);
  assign push_new  = in_fire && in_keep && hold_q.vld;
  assign flush     = hold_q.vld && hold_q.last && o_free;
  assign empty_end = in_fire && !in_keep && in_last && !hold_q.vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      out_q     <= '0;
      run_cnt   <= '0;
      cnt_out   <= '0;
      cnt_valid <= 1'b0;
    end else begin
      cnt_valid <= 1'b0;
      // output register
      if (push_new || flush)
        out_q <= '{vld: 1'b1, data: hold_q.data, last: flush};
      else if (out_ready)
        out_q.vld <= 1'b0;
      // holding slot: one kept bit waits until its successor is known
      if (in_fire && in_keep)
        hold_q <= '{vld: 1'b1, data: in_bit, last: in_last};
      else if (in_fire && in_last)
        hold_q.last <= hold_q.vld;
      else if (flush)
        hold_q <= '0;
      // per-frame count
      if (flush) begin
        cnt_out   <= run_cnt + CNT_W'(1);
        cnt_valid <= 1'b1;
        run_cnt   <= '0;
      end else if (push_new) begin
        run_cnt <= run_cnt + CNT_W'(1);
      end else if (empty_end) begin
        cnt_out   <= '0;
        cnt_valid <= 1'b1;
      end
    end
  end

  assign out_valid = out_q.vld;
  assign out_bit   = out_q.data;
  assign out_last  = out_q.last;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_last)));
  // R1
  kept_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (in_fire && in_keep) |=> hold_q.vld);
endmodule

// File: rtl/punct_rate_ctrl.sv
module punct_rate_ctrl #(
  parameter int DEN_W = 4,
  parameter int MIN_N = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEN_W:0]   rate_sel,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bit,
  input  logic             in_par,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_bit,
  output logic             out_last,
  output logic [CNT_W-1:0] frame_bits,
  output logic             frame_bits_valid,
  output logic             cfg_err
);
  logic [DEN_W:0] n_eff;
  logic           pat_keep, in_fire, keep;

  assign in_fire = in_valid && in_ready;
  assign keep    = !in_par || pat_keep;

  punct_cfg #(.DEN_W(DEN_W), .MIN_N(MIN_N)) u_cfg (
    .clk(clk), .rst(rst), .rate_in(rate_sel), .n_eff(n_eff), .cfg_err(cfg_err)
  );

  punct_pattern #(.DEN_W(DEN_W)) u_pat (
    .clk(clk), .rst(rst), .step(in_fire && in_par),
    .frame_end(in_fire && in_last), .n_eff(n_eff), .keep(pat_keep)
  );

  punct_hold #(.CNT_W(CNT_W)) u_hold (
    .clk(clk), .rst(rst), .in_fire(in_fire), .in_keep(keep), .in_bit(in_bit),
    .in_last(in_last), .in_ready(in_ready), .out_ready(out_ready),
    .out_valid(out_valid), .out_bit(out_bit), .out_last(out_last),
    .cnt_out(frame_bits), .cnt_valid(frame_bits_valid)
  );
endmodule

// File: tb/punct_rate_ctrl_bench.sv
`timescale 1ns/1ps
module punct_rate_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rate_sel = 5'd16;
  logic        in_valid = 1'b0, in_bit = 1'b0, in_par = 1'b0, in_last = 1'b0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, out_bit, out_last, frame_bits_valid, cfg_err;
  logic [15:0] frame_bits;

  always #2 clk = ~clk;

  punct_rate_ctrl u_punct_rate_ctrl (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_par(in_par), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_bit(out_bit), .out_last(out_last),
    .frame_bits(frame_bits), .frame_bits_valid(frame_bits_valid), .cfg_err(cfg_err)
  );

  int checks = 0, errors = 0;
  logic fb [64];
  logic fp [64];
  int   flen;
  logic eb [128];
  logic rb [128];
  int   elen, nsys, kept, rcnt, last_cnt, last_idx, got_val;
  bit   got_cnt;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_n(input int n);
    return (n < 8 || n > 16) ? 16 : n;
  endfunction

  task automatic build_expect(input int n);
    int ph = 0;
    elen = 0; nsys = 0; kept = 0;
    for (int i = 0; i < flen; i++) begin
      if (!fp[i]) begin
        eb[elen] = fb[i]; elen++; nsys++;
      end else begin
        int s = ph + n;
        if (s >= 16) begin eb[elen] = fb[i]; elen++; kept++; end
        ph = s % 16;
      end
    end
  endtask

  task automatic run_frame(input int n_sel, input string tag);
    int idx = 0;
    bit fire = 0;
    build_expect(eff_n(n_sel));
    rcnt = 0; last_cnt = 0; last_idx = -1; got_cnt = 0; got_val = -1;
    @(negedge clk);
    rate_sel = 5'(n_sel);
    while (!(got_cnt && (elen == 0 || last_cnt > 0))) begin
      @(negedge clk);
      if (fire) idx++;
      if (idx < flen) begin
        in_valid = 1'b1; in_bit = fb[idx]; in_par = fp[idx]; in_last = (idx == flen - 1);
      end else begin
        in_valid = 1'b0; in_last = 1'b0;
      end
      out_ready = ($urandom % 4) != 0;
      #1;
      if (out_valid && out_ready) begin
        if (rcnt < 128) rb[rcnt] = out_bit;
        if (out_last) begin last_cnt++; last_idx = rcnt; end
        rcnt++;
      end
      if (frame_bits_valid) begin got_cnt = 1; got_val = int'(frame_bits); end
      fire = in_valid && in_ready;
    end
    // R1 R2 R8: stream content and length
    check(rcnt == elen, {tag, " R1 R2 R8 length"}, rcnt, elen);
    begin
      int bad = -1;
      for (int i = 0; i < elen && i < rcnt; i++)
        if (bad < 0 && rb[i] !== eb[i]) bad = i;
      check(bad < 0, {tag, " R1 R2 R8 first bad index"}, bad, -1);
    end
    // R5
    check(last_cnt == (elen > 0 ? 1 : 0), {tag, " R5 last count"}, last_cnt, elen > 0 ? 1 : 0);
    if (elen > 0) check(last_idx == elen - 1, {tag, " R5 last position"}, last_idx, elen - 1);
    // R6
    check(got_val == nsys + kept, {tag, " R6 frame count"}, got_val, nsys + kept);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R9
    check(out_valid == 0 && frame_bits_valid == 0, "R9 outputs idle", out_valid, 0);
    check(cfg_err == 0, "R9 cfg_err clear", cfg_err, 0);
    check(in_ready == 1, "R9 in_ready", in_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();

    // R3: N = 16 transparent
    flen = 40;
    for (int i = 0; i < flen; i++) begin fb[i] = $urandom % 2; fp[i] = $urandom % 2; end
    run_frame(16, "n16");
    check(elen == flen, "R3 all bits kept", elen, flen);

    // R4: 32 parity bits with N = 12 keep 24
    flen = 32;
    for (int i = 0; i < flen; i++) begin fb[i] = $urandom % 2; fp[i] = 1'b1; end
    run_frame(12, "n12");
    check(rcnt == 24, "R4 kept 12 of 16 twice", rcnt, 24);

    // R5: final parity bit deleted (N = 8, 15 parity after one systematic)
    flen = 16;
    fb[0] = 1'b1; fp[0] = 1'b0;
    for (int i = 1; i < flen; i++) begin fb[i] = $urandom % 2; fp[i] = 1'b1; end
    run_frame(8, "dropend");
    check(rcnt == 8, "R4 R5 N=8 drop-last count", rcnt, 8);

    // R10: frame with one deleted parity bit only
    flen = 1; fb[0] = 1'b1; fp[0] = 1'b1;
    run_frame(8, "empty");
    check(rcnt == 0, "R10 nothing emitted", rcnt, 0);

    // R2: pattern restarts per frame: same frame twice at N = 9
    flen = 20;
    for (int i = 0; i < flen; i++) begin fb[i] = $urandom % 2; fp[i] = 1'b1; end
    run_frame(9, "restartA");
    run_frame(9, "restartB");

    // random frames and settings
    for (int f = 0; f < 30; f++) begin
      flen = 1 + $urandom % 60;
      for (int i = 0; i < flen; i++) begin fb[i] = $urandom % 2; fp[i] = ($urandom % 3) != 0; end
      run_frame(8 + $urandom % 9, "rand");
    end

    // R7: out-of-range setting clamps to 16 and sets sticky error
    flen = 24;
    for (int i = 0; i < flen; i++) begin fb[i] = $urandom % 2; fp[i] = 1'b1; end
    run_frame(5, "clamp");
    check(rcnt == 24, "R7 clamp keeps all parity", rcnt, 24);
    check(cfg_err == 1, "R7 cfg_err set", cfg_err, 1);
    run_frame(10, "after_err");
    check(cfg_err == 1, "R7 cfg_err sticky", cfg_err, 1);
    do_reset();

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule